// File: doc/BRIEF.md
# FM Frame Receiver with Channel Latch

This block takes the raw data line of a simple radio receiver and turns it into four switched outputs. The line is synchronised to the clock and sampled on a slow tick. A level change is passed on only once it has stayed put for a run of samples, so short glitches from the radio are removed. The decoder measures the time between accepted transitions. It recovers frequency-modulated bits: every bit is bounded by transitions, and a zero has one more transition in the middle.

Twenty-four bits form one frame, least significant bit first. The frame holds three bytes: a channel address, a command value and a check byte. The frame is used only if the three bytes add to zero modulo 256 and the address lies in a four-entry window starting at a base address. The address offset then picks one output. A command with its top bit set turns that output on. Any other command turns it off. Outputs keep their state until a later valid frame addresses them.

Top module: `fm_frame_rx`

## Requirements
- R1: The input must hold a new level for 4 consecutive tick samples before it counts as a transition. A pulse shorter than that, whether between frames or inside a bit, has no effect on the decoded frame or on the outputs.
- R2: The first accepted transition while unsynchronised starts a frame: the bit count is cleared and the interval timer restarts.
- R2 (bit decoding): A later transition that comes at least 300 us (75 ticks of 4 us) after the timer reference is decoded as a 1. A transition that comes sooner is the middle of a 0. In that case the timer is preset to 300 us and the next transition completes the 0.
- R3: Bits fill a 24-bit frame least significant bit first. The first byte is the address, the second the command value and the third the check byte.
- R4: A frame whose three bytes do not add to 0 modulo 256 changes no output.
- R5: A frame whose address minus 0xA0 is outside 0..3 changes no output (for example 0xA4 or 0x9F).
- R6: In a valid frame, address offset k selects output bit k. A command value of 0x80 or more sets that bit, and a value of 0x7F or less clears it.
- R7: All outputs are low after reset, including a reset applied in mid-run. Between valid frames they hold their state, and a valid frame changes only the bit it selects.
- R8: If no transition arrives within 600 us (150 ticks) of the timer reference, sync is lost. A frame interrupted by such a pause is not accepted.
- R9: A frame is evaluated once, when the bit count reaches 24. Further bits before sync is lost do not trigger a second evaluation, and the count saturates at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Raw serial data from the radio receiver |
| chan_q | output | NUM_OUT | Latched on/off state of each output channel |

## Verification
On every cycle the assertions check four things. An accepted transition is never repeated on the next cycle. Sync rises only after an accepted transition, and bits are decoded only while synchronised. Between frame acceptances the outputs hold their value, and a single acceptance changes at most one output bit. The bench scenarios are the only evidence for the decoded values themselves. These cover least-significant-bit-first byte order, the checksum and address-window rejections, the 0x80/0x7F command boundary, glitch immunity inside a bit, rejection of a frame split by a long pause, and single evaluation when extra bits follow a frame.

// File: rtl/fm_rx_pkg.sv
package fm_rx_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int BITCNT_W    = 8;

  typedef logic [BYTE_W-1:0] fbyte_t;

  // Bit 0 of the packed vector is the first bit on air.
  typedef struct packed {
    fbyte_t check;
    fbyte_t value;
    fbyte_t addr;
  } frame_t;
endpackage

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          tick_d;

      always_comb begin
        tick_d = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CW'(DIV - 1)) begin
          cnt_d  = '0;
          tick_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_o = tick_d;
    end
  endgenerate
endmodule

// File: rtl/fm_edge_filter.sv
module fm_edge_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic edge_o
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [1:0]    meta_q;
  logic          run_lvl_q, run_lvl_d;
  logic [CW-1:0] run_cnt_q, run_cnt_d;
  logic          acc_q, acc_d;
  logic          edge_d;

  // Run counter restarts on every level change of the sampled input and
  // saturates at RUN_LEN; a transition is reported only when a run of the
  // required length differs from the last accepted level.
  always_comb begin
    run_lvl_d = run_lvl_q;
    run_cnt_d = run_cnt_q;
    acc_d     = acc_q;
    edge_d    = 1'b0;
    if (tick_i) begin
      if (meta_q[1] != run_lvl_q) begin
        run_lvl_d = meta_q[1];
        run_cnt_d = CW'(1);
      end else if (run_cnt_q != CW'(RUN_LEN)) begin
        run_cnt_d = run_cnt_q + 1'b1;
      end
      if ((run_cnt_d == CW'(RUN_LEN)) && (run_lvl_d != acc_q)) begin
        edge_d = 1'b1;
        acc_d  = run_lvl_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      run_lvl_q <= 1'b0;
      run_cnt_q <= CW'(RUN_LEN);
      acc_q     <= 1'b0;
    end else begin
      meta_q    <= {meta_q[0], raw_i};
      run_lvl_q <= run_lvl_d;
      run_cnt_q <= run_cnt_d;
      acc_q     <= acc_d;
    end
  end

  assign edge_o = edge_d;
endmodule

// File: rtl/fm_bit_decoder.sv
module fm_bit_decoder #(
  parameter int ONE_TICKS  = 75,
  parameter int LOSS_TICKS = 150,
  parameter int TW         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic edge_i,
  output logic restart_o,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic sync_o
);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  logic          sync_q, sync_d;
  logic          half_q, half_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] elapsed;
  logic          restart_d, bvld_d, bval_d;

  assign elapsed = (tmr_q == TMAX) ? tmr_q : tmr_q + 1'b1;

  always_comb begin
    sync_d    = sync_q;
    half_d    = half_q;
    tmr_d     = tmr_q;
    restart_d = 1'b0;
    bvld_d    = 1'b0;
    bval_d    = 1'b0;
    if (tick_i) begin
      tmr_d = elapsed;
      if (edge_i) begin
        if (!sync_q) begin
          sync_d    = 1'b1;
          half_d    = 1'b0;
          tmr_d     = '0;
          restart_d = 1'b1;
        end else if (half_q) begin
          bvld_d = 1'b1;
          bval_d = 1'b0;
          half_d = 1'b0;
          tmr_d  = '0;
        end else if (elapsed >= TW'(ONE_TICKS)) begin
          bvld_d = 1'b1;
          bval_d = 1'b1;
          tmr_d  = '0;
        end else begin
          half_d = 1'b1;
          tmr_d  = TW'(ONE_TICKS);
        end
      end else if (sync_q && (elapsed >= TW'(LOSS_TICKS))) begin
        sync_d = 1'b0;
        half_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      half_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      sync_q <= sync_d;
      half_q <= half_d;
      tmr_q  <= tmr_d;
    end
  end

  assign restart_o = restart_d;
  assign bit_vld_o = bvld_d;
  assign bit_val_o = bval_d;
  assign sync_o    = sync_q;
endmodule

// File: rtl/fm_frame_assembler.sv
module fm_frame_assembler
  import fm_rx_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'hA0,
  parameter int         NUM_OUT   = 4,
  parameter int         SW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          bit_vld_i,
  input  logic          bit_val_i,
  output logic          frame_ok_o,
  output logic [SW-1:0] sel_o,
  output logic          on_o
);
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [BITCNT_W-1:0]   cnt_q, cnt_d;
  logic                  chk_q, chk_d;
  frame_t                frm;
  fbyte_t                sum, offset;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    chk_d = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (bit_vld_i) begin
      sr_d  = {bit_val_i, sr_q[FRAME_BITS-1:1]};
      cnt_d = (cnt_q == {BITCNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
      chk_d = (cnt_q == BITCNT_W'(FRAME_BITS - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      chk_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      chk_q <= chk_d;
    end
  end

  assign frm    = frame_t'(sr_q);
  assign sum    = frm.addr + frm.value + frm.check;
  assign offset = frm.addr - ADDR_BASE;

  assign frame_ok_o = chk_q && (sum == '0) && (offset < BYTE_W'(NUM_OUT));
  assign sel_o      = offset[SW-1:0];
  assign on_o       = frm.value[BYTE_W-1];
endmodule

// File: rtl/fm_out_latch.sv
module fm_out_latch #(
  parameter int NUM_OUT = 4,
  parameter int SW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [SW-1:0]      sel_i,
  input  logic               on_i,
  output logic [NUM_OUT-1:0] q_o
);
  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
      logic q_q, q_d;

      always_comb begin
        q_d = q_q;
        if (load_i && (sel_i == SW'(g))) begin
          q_d = on_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_q <= 1'b0;
        end else begin
          q_q <= q_d;
        end
      end

      assign q_o[g] = q_q;
    end
  endgenerate
endmodule

// File: rtl/fm_frame_rx.sv
module fm_frame_rx #(
  parameter int         CLK_HZ      = 4_000_000,
  parameter int         TICK_US     = 4,
  parameter int         ONE_MIN_US  = 300,
  parameter int         LOSS_US     = 600,
  parameter int         RUN_LEN     = 4,
  parameter logic [7:0] ADDR_BASE   = 8'hA0,
  parameter int         NUM_OUT     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_in,
  output logic [NUM_OUT-1:0] chan_q
);
  localparam int TICK_RAW   = (CLK_HZ / 1000) * TICK_US / 1000;
  localparam int TICK_DIV   = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int ONE_TICKS  = ONE_MIN_US / TICK_US;
  localparam int LOSS_TICKS = LOSS_US / TICK_US;
  localparam int TW         = $clog2(LOSS_TICKS + 1);
  localparam int SW         = $clog2(NUM_OUT);

  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic          tick;
  logic          flt_edge;
  logic          dec_restart, dec_bit_vld, dec_bit_val, dec_sync;
  logic          frame_ok;
  logic [SW-1:0] frame_sel;
  logic          frame_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  fm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_o (tick)
  );

  fm_edge_filter #(.RUN_LEN(RUN_LEN)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_i (tick),
    .raw_i  (rx_in),
    .edge_o (flt_edge)
  );

  fm_bit_decoder #(
    .ONE_TICKS  (ONE_TICKS),
    .LOSS_TICKS (LOSS_TICKS),
    .TW         (TW)
  ) u_decoder (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_i    (tick),
    .edge_i    (flt_edge),
    .restart_o (dec_restart),
    .bit_vld_o (dec_bit_vld),
    .bit_val_o (dec_bit_val),
    .sync_o    (dec_sync)
  );

  fm_frame_assembler #(
    .ADDR_BASE (ADDR_BASE),
    .NUM_OUT   (NUM_OUT),
    .SW        (SW)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .restart_i  (dec_restart),
    .bit_vld_i  (dec_bit_vld),
    .bit_val_i  (dec_bit_val),
    .frame_ok_o (frame_ok),
    .sel_o      (frame_sel),
    .on_o       (frame_on)
  );

  fm_out_latch #(.NUM_OUT(NUM_OUT), .SW(SW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (frame_ok),
    .sel_i  (frame_sel),
    .on_i   (frame_on),
    .q_o    (chan_q)
  );
endmodule

// File: rtl/fm_frame_rx_chk.sv
module fm_frame_rx_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               edge_i,
  input logic               sync_i,
  input logic               bit_vld_i,
  input logic               frame_ok_i,
  input logic [NUM_OUT-1:0] chan_i
);
  // R1: a level run yields one accepted transition, never two in a row
  assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !edge_i);

  // R2: sync can only be gained on an accepted transition
  assert_sync_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_i) |-> $past(edge_i));

  // R2: bits are decoded only while synchronised
  assert_bit_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_i |-> sync_i);

  // R7: outputs hold unless a frame was accepted
  assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok_i |=> $stable(chan_i));

  // R6: one accepted frame touches at most one channel
  assert_one_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_i |=> ($countones(chan_i ^ $past(chan_i)) <= 1));
endmodule

bind fm_frame_rx fm_frame_rx_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .edge_i     (flt_edge),
  .sync_i     (dec_sync),
  .bit_vld_i  (dec_bit_vld),
  .frame_ok_i (frame_ok),
  .chan_i     (chan_q)
);

// File: tb/test_fm_frame_rx.sv
`timescale 1ns/1ps
module test_fm_frame_rx;
  // 500 kHz nominal rate -> one 4 us tick every 2 clocks
  localparam int TICK_CLKS = 2;
  localparam int T_ONE     = 100;  // full bit, ticks
  localparam int T_HALF    = 50;   // half bit, ticks
  localparam int T_GAP     = 300;  // idle gap, beyond sync loss
  localparam int NVEC      = 10;

  // {addr, value, bad_ck nibble, req nibble, 4'h0, expected outputs}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA0FF_0601,  // R6 set ch0
    32'hA280_0605,  // R6 0x80 boundary sets ch2
    32'hA3C3_030D,  // R3 ch3
    32'hA1FF_140D,  // R4 bad checksum
    32'hA4FF_050D,  // R5 above window
    32'h9FFF_050D,  // R5 below window
    32'hA07F_060C,  // R6 0x7F clears ch0
    32'hA1FF_030E,  // R3 ch1
    32'hA300_0706,  // R7 clear ch3, others hold
    32'hA201_0702   // R7 clear ch2
  };

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic [3:0] chan;
  int         n_run;
  int         n_fail;
  bit         done;

  fm_frame_rx #(.CLK_HZ(500_000)) i_fm_frame_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_in  (rx),
    .chan_q (chan)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wait_ticks(input int n);
    repeat (n * TICK_CLKS) @(negedge clk);
  endtask

  task automatic flip();
    rx = ~rx;
  endtask

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: chan=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] mk_frame(input logic [7:0] a, input logic [7:0] v, input bit bad);
    logic [7:0] ck;
    ck = 8'h00 - a - v;
    if (bad) ck = ck + 8'h01;
    return {ck, v, a};
  endfunction

  // Sends nbits of w, LSB first, then an idle gap; glitch inserts a
  // 2-tick pulse into the first 1 bit.
  task automatic send_bits(input logic [31:0] w, input int nbits, input bit glitch);
    bit gl;
    gl = glitch;
    flip();  // sync transition
    for (int i = 0; i < nbits; i++) begin
      if (w[i]) begin
        if (gl) begin
          wait_ticks(40); flip(); wait_ticks(2); flip(); wait_ticks(T_ONE - 42);
          gl = 1'b0;
        end else begin
          wait_ticks(T_ONE);
        end
        flip();
      end else begin
        wait_ticks(T_HALF); flip(); wait_ticks(T_HALF); flip();
      end
    end
    wait_ticks(T_GAP);
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    done   = 1'b0;
    rx     = 1'b0;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    check(chan, 4'b0000, "R7 reset state");
    rst_n = 1'b1;
    wait_ticks(20);

    for (int k = 0; k < NVEC; k++) begin
      send_bits({8'h00, mk_frame(VEC[k][31:24], VEC[k][23:16], VEC[k][12])}, 24, 1'b0);
      check(chan, VEC[k][3:0], $sformatf("R%0d vector %0d", VEC[k][11:8], k));
    end

    // R1: glitch inside a 1 bit does not corrupt the frame
    send_bits({8'h00, mk_frame(8'hA0, 8'hFF, 1'b0)}, 24, 1'b1);
    check(chan, 4'b0011, "R1 glitch inside bit");

    // R1: idle glitch shorter than the run length
    flip(); wait_ticks(2); flip(); wait_ticks(T_GAP);
    send_bits({8'h00, mk_frame(8'hA1, 8'h00, 1'b0)}, 0, 1'b0);
    check(chan, 4'b0011, "R1 idle glitch");

    // R8: frame split by a pause longer than 600 us is dropped
    begin
      logic [23:0] f;
      f = mk_frame(8'hA1, 8'h00, 1'b0);
      send_bits({8'h00, f}, 10, 1'b0);
      send_bits({18'h0, f[23:10]}, 14, 1'b0);
    end
    check(chan, 4'b0011, "R8 split frame");

    // R9: extra bits after the 24th do not re-evaluate
    send_bits({8'h15, mk_frame(8'hA3, 8'hFF, 1'b0)}, 29, 1'b0);
    check(chan, 4'b1011, "R9 trailing bits");

    // R7: reset in mid-run clears outputs
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(chan, 4'b0000, "R7 mid-run reset");
    rst_n = 1'b1;
    wait_ticks(10);
    check(chan, 4'b0000, "R7 after reset release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule